// File: doc/BRIEF.md
# Eight-Way Pseudo-LRU Victim Selector

This block picks the way to replace when an eight-way set-associative cache must allocate a line. Each set owns a small binary-tree pseudo-LRU vector held in the block. A hit or a fill on a way is reported through a touch strobe, and the tree path to that way is rewritten so that it points away from that way. A lookup of a set returns a victim way in the same cycle. The search follows the tree pointers but turns aside at any node whose pointed half holds no eligible way.

A way is eligible for a request only if it is unlocked and its class may use it. A configurable group of 1, 2 or 4 top ways can be reserved for I/O stash writes. Processor instruction and data requests never allocate there. Stash requests allocate nowhere else. Processor allocation can be enabled for instructions, for data, or for both. When no way is eligible, the block raises a no-victim flag and the caller serves the request without allocating. Tag lookup, data storage and line state are handled by neighbouring blocks. The stash decision (a stash attribute on the request, or an address inside a programmed window) is made upstream and arrives here as the request class.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every set's tree points to way 0, so a set whose eight ways are all eligible returns victim 0.
- R2: A touch of way w on a set rewrites that set's tree path so that it points away from w. Tree bit 0 is the root, and bits 2n+1 and 2n+2 are the children of bit n. A pointer of 0 selects the lower-numbered half. Starting from reset, touching each returned victim in turn on one set yields victims 0, 4, 2, 6, 1, 5, 3, 7.
- R3: A touch alters only the tree of the set it names.
- R4: A locked way is never returned. When every way on the pointed side of a node is ineligible, the search takes the other side.
- R5: The stash-reserve code is 0 (none), 1 (way 7), 2 (ways 6-7) or 3 (ways 4-7). Instruction (class 0) and data (class 1) requests never receive a reserved way.
- R6: Stash requests (class 2) receive only reserved ways. With reserve code 0 they receive no victim.
- R7: Allocation enable bit 0 permits instruction allocation and bit 1 permits data allocation. A class whose bit is clear receives no victim.
- R8: When no way is eligible, no_victim is 1 and victim_way is 0.
- R9: The victim follows the lookup inputs in the same cycle. A touch takes effect at the next clock edge, so a lookup of the touched set in the touch cycle still sees the old tree.
- R10: Request class 3 is reserved and never receives a victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_set | input | SET_W | Set being looked up for a victim |
| req_class | input | 2 | 0 instruction, 1 data, 2 I/O stash, 3 reserved |
| lock_mask | input | WAYS | Per-way lock bits of the looked-up set |
| cfg_stash_ways | input | 2 | Stash reserve code (0, 1, 2 or 4 top ways) |
| cfg_alloc_en | input | 2 | Bit 0 instruction allocation, bit 1 data allocation |
| touch_valid | input | 1 | Hit or fill strobe |
| touch_set | input | SET_W | Set of the hit or fill |
| touch_way | input | WAY_W | Way of the hit or fill |
| victim_way | output | WAY_W | Chosen replacement way |
| no_victim | output | 1 | No eligible way exists in the set |

## Verification
The hardest situation to reach is a tree whose pointers lead into a half with no eligible way, so that the search must turn aside at an inner node rather than at the root. The stimulus first walks one set through a known sequence of touches to put the tree into a fixed mixed pattern. It then applies lock masks and stash reserve codes that empty exactly the pointed half, or exactly one pointed leaf. A directed step also touches a set and looks it up in the same cycle, which shows the one-edge delay of the update.

// File: rtl/plru_pkg.sv
package plru_pkg;

   typedef enum logic [1:0] {
      REQ_INSTR = 2'b00,
      REQ_DATA  = 2'b01,
      REQ_STASH = 2'b10,
      REQ_RSVD  = 2'b11
   } req_class_e;

   // Number of top ways reserved for stashing, from the 2-bit code.
   function automatic int stash_count(input logic [1:0] code);
      case (code)
         2'd1:    return 1;
         2'd2:    return 2;
         2'd3:    return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/plru_state_store.sv
module plru_state_store #(
   parameter int NUM_SETS  = 2048,
   parameter int TREE_BITS = 7,
   localparam int SET_W    = $clog2(NUM_SETS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SET_W-1:0]     lkp_set,
   output logic [TREE_BITS-1:0] lkp_bits,
   input  logic [SET_W-1:0]     upd_set,
   output logic [TREE_BITS-1:0] upd_old_bits,
   input  logic                 upd_en,
   input  logic [TREE_BITS-1:0] upd_new_bits
);

   logic [TREE_BITS-1:0] tree_q [NUM_SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            tree_q[s] <= '0;
         end
      end else if (upd_en) begin
         tree_q[upd_set] <= upd_new_bits;
      end
   end

   assign lkp_bits     = tree_q[lkp_set];
   assign upd_old_bits = tree_q[upd_set];

endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update #(
   parameter int WAYS       = 8,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int TREE_BITS = WAYS - 1
) (
   input  logic [TREE_BITS-1:0] old_bits,
   input  logic [WAY_W-1:0]     way,
   output logic [TREE_BITS-1:0] new_bits
);

   // Walk the path from the root to the touched leaf; every node on it
   // is turned towards the half that does not contain the touched way.
   always_comb begin
      new_bits = old_bits;
      for (int lvl = 0; lvl < WAY_W; lvl++) begin
         int                   node;
         logic                 way_hi;
         logic [TREE_BITS-1:0] sel;
         node   = (1 << lvl) - 1 + (int'(way) >> (WAY_W - lvl));
         way_hi = ((int'(way) >> (WAY_W - 1 - lvl)) & 1) != 0;
         sel    = TREE_BITS'(1) << node;
         if (way_hi) new_bits = new_bits & ~sel;
         else        new_bits = new_bits | sel;
      end
   end

endmodule

// File: rtl/plru_elig_mask.sv
module plru_elig_mask
   import plru_pkg::*;
#(
   parameter int WAYS = 8
) (
   input  logic [1:0]      req_class,
   input  logic [WAYS-1:0] lock_mask,
   input  logic [1:0]      cfg_stash_ways,
   input  logic [1:0]      cfg_alloc_en,
   output logic [WAYS-1:0] elig_mask
);

   int              reserve_cnt;
   logic [WAYS-1:0] reserved;
   req_class_e      cls;

   assign reserve_cnt = stash_count(cfg_stash_ways);
   assign cls         = req_class_e'(req_class);

   // Reserved region sits at the top of the way range.
   for (genvar g = 0; g < WAYS; g++) begin : g_reserve
      assign reserved[g] = (reserve_cnt != 0) && (g >= (WAYS - reserve_cnt));
   end

   always_comb begin
      case (cls)
         REQ_INSTR: elig_mask = cfg_alloc_en[0] ? (~reserved & ~lock_mask) : '0;
         REQ_DATA:  elig_mask = cfg_alloc_en[1] ? (~reserved & ~lock_mask) : '0;
         REQ_STASH: elig_mask = reserved & ~lock_mask;
         default:   elig_mask = '0;
      endcase
   end

endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk #(
   parameter int WAYS       = 8,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int TREE_BITS = WAYS - 1
) (
   input  logic [TREE_BITS-1:0] tree_bits,
   input  logic [WAYS-1:0]      elig_mask,
   output logic [WAY_W-1:0]     victim_way,
   output logic                 none_left
);

   assign none_left = ~|elig_mask;

   always_comb begin
      logic [WAY_W-1:0] prefix;
      int               node;
      prefix = '0;
      node   = 0;
      for (int lvl = 0; lvl < WAY_W; lvl++) begin
         logic lo_any;
         logic hi_any;
         logic ptr;
         logic take_hi;
         lo_any = 1'b0;
         hi_any = 1'b0;
         for (int w = 0; w < WAYS; w++) begin
            if ((w >> (WAY_W - lvl - 1)) == (int'(prefix) << 1))
               lo_any = lo_any | elig_mask[w];
            if ((w >> (WAY_W - lvl - 1)) == ((int'(prefix) << 1) + 1))
               hi_any = hi_any | elig_mask[w];
         end
         ptr     = |(tree_bits & (TREE_BITS'(1) << node));
         take_hi = ptr ? (hi_any || !lo_any) : (hi_any && !lo_any);
         prefix  = {prefix[WAY_W-2:0], take_hi};
         node    = 2 * node + 1 + int'(take_hi);
      end
      victim_way = none_left ? '0 : prefix;
   end

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
   parameter int NUM_SETS = 2048,
   parameter int WAYS     = 8,
   localparam int SET_W     = $clog2(NUM_SETS),
   localparam int WAY_W     = $clog2(WAYS),
   localparam int TREE_BITS = WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lkp_set,
   input  logic [1:0]       req_class,
   input  logic [WAYS-1:0]  lock_mask,
   input  logic [1:0]       cfg_stash_ways,
   input  logic [1:0]       cfg_alloc_en,
   input  logic             touch_valid,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim_way,
   output logic             no_victim
);

   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 8) begin : g_bad_ways
      $error("plru_victim_sel: WAYS must be a power of two, at least 8");
   end
   if ((NUM_SETS & (NUM_SETS - 1)) != 0 || NUM_SETS < 2) begin : g_bad_sets
      $error("plru_victim_sel: NUM_SETS must be a power of two, at least 2");
   end

   logic [TREE_BITS-1:0] lkp_bits;
   logic [TREE_BITS-1:0] upd_old_bits;
   logic [TREE_BITS-1:0] upd_new_bits;
   logic [WAYS-1:0]      elig_mask;

   plru_state_store #(
      .NUM_SETS  (NUM_SETS),
      .TREE_BITS (TREE_BITS)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .lkp_set      (lkp_set),
      .lkp_bits     (lkp_bits),
      .upd_set      (touch_set),
      .upd_old_bits (upd_old_bits),
      .upd_en       (touch_valid),
      .upd_new_bits (upd_new_bits)
   );

   plru_tree_update #(
      .WAYS (WAYS)
   ) u_update (
      .old_bits (upd_old_bits),
      .way      (touch_way),
      .new_bits (upd_new_bits)
   );

   plru_elig_mask #(
      .WAYS (WAYS)
   ) u_elig (
      .req_class      (req_class),
      .lock_mask      (lock_mask),
      .cfg_stash_ways (cfg_stash_ways),
      .cfg_alloc_en   (cfg_alloc_en),
      .elig_mask      (elig_mask)
   );

   plru_tree_walk #(
      .WAYS (WAYS)
   ) u_walk (
      .tree_bits  (lkp_bits),
      .elig_mask  (elig_mask),
      .victim_way (victim_way),
      .none_left  (no_victim)
   );

endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk
   import plru_pkg::*;
#(
   parameter int SET_W = 11,
   parameter int WAYS  = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SET_W-1:0] lkp_set,
   input logic [1:0]       req_class,
   input logic [WAYS-1:0]  lock_mask,
   input logic [1:0]       cfg_stash_ways,
   input logic [1:0]       cfg_alloc_en,
   input logic             touch_valid,
   input logic [SET_W-1:0] touch_set,
   input logic [WAY_W-1:0] touch_way,
   input logic [WAYS-1:0]  elig_mask,
   input logic [WAY_W-1:0] victim_way,
   input logic             no_victim
);

   int   rsv;
   logic armed;

   assign rsv = stash_count(cfg_stash_ways);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !no_victim |-> !lock_mask[victim_way]); // R4

   AST_VICTIM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      !no_victim |-> elig_mask[victim_way]); // R4

   AST_PROC_OUTSIDE_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_victim && (req_class == REQ_INSTR || req_class == REQ_DATA))
      |-> (int'(victim_way) < WAYS - rsv)); // R5

   AST_STASH_INSIDE_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_victim && req_class == REQ_STASH)
      |-> (rsv != 0 && int'(victim_way) >= WAYS - rsv)); // R6

   AST_DISABLED_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_class == REQ_INSTR && !cfg_alloc_en[0]) |-> no_victim); // R7

   AST_DISABLED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (req_class == REQ_DATA && !cfg_alloc_en[1]) |-> no_victim); // R7

   AST_RESERVED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_class == REQ_RSVD) |-> no_victim); // R10

   AST_NO_VICTIM_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      no_victim |-> (victim_way == '0)); // R8

   AST_TOUCH_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(touch_valid) && (lkp_set == $past(touch_set))
       && ($countones(elig_mask) > 1))
      |-> (victim_way != $past(touch_way))); // R2

endmodule

bind plru_victim_sel plru_victim_sel_chk #(
   .SET_W (SET_W),
   .WAYS  (WAYS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lkp_set        (lkp_set),
   .req_class      (req_class),
   .lock_mask      (lock_mask),
   .cfg_stash_ways (cfg_stash_ways),
   .cfg_alloc_en   (cfg_alloc_en),
   .touch_valid    (touch_valid),
   .touch_set      (touch_set),
   .touch_way      (touch_way),
   .elig_mask      (elig_mask),
   .victim_way     (victim_way),
   .no_victim      (no_victim)
);

// File: tb/plru_victim_sel_bench.sv
module plru_victim_sel_bench;

   localparam int NUM_SETS = 2048;
   localparam int WAYS     = 8;
   localparam int SET_W    = $clog2(NUM_SETS);
   localparam int WAY_W    = $clog2(WAYS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [SET_W-1:0] lkp_set = '0;
   logic [1:0]       req_class = '0;
   logic [WAYS-1:0]  lock_mask = '0;
   logic [1:0]       cfg_stash_ways = '0;
   logic [1:0]       cfg_alloc_en = 2'b11;
   logic             touch_valid = 1'b0;
   logic [SET_W-1:0] touch_set = '0;
   logic [WAY_W-1:0] touch_way = '0;
   logic [WAY_W-1:0] victim_way;
   logic             no_victim;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   plru_victim_sel #(
      .NUM_SETS (NUM_SETS),
      .WAYS     (WAYS)
   ) u_plru_victim_sel (
      .clk            (clk),
      .rst_n          (rst_n),
      .lkp_set        (lkp_set),
      .req_class      (req_class),
      .lock_mask      (lock_mask),
      .cfg_stash_ways (cfg_stash_ways),
      .cfg_alloc_en   (cfg_alloc_en),
      .touch_valid    (touch_valid),
      .touch_set      (touch_set),
      .touch_way      (touch_way),
      .victim_way     (victim_way),
      .no_victim      (no_victim)
   );

   typedef struct packed {
      logic             tv;
      logic [SET_W-1:0] ts;
      logic [WAY_W-1:0] tw;
      logic [SET_W-1:0] qs;
      logic [1:0]       qc;
      logic [WAYS-1:0]  lk;
      logic [1:0]       sc;
      logic [1:0]       al;
      logic [WAY_W-1:0] ew;
      logic             en;
      logic [3:0]       req;
   } vec_t;

   localparam int NVEC = 24;
   // tv ts tw | qs qc lock sc al | exp_way exp_nv req
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd0, 1'b0, 4'd1},  // R1
      '{1'b1, 11'd5, 3'd0, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd4, 1'b0, 4'd2},  // R2
      '{1'b1, 11'd5, 3'd4, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd2, 1'b0, 4'd2},  // R2
      '{1'b1, 11'd5, 3'd2, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd6, 1'b0, 4'd2},  // R2
      '{1'b1, 11'd5, 3'd6, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd1, 1'b0, 4'd2},  // R2
      '{1'b1, 11'd5, 3'd1, 11'd5, 2'd0, 8'h00, 2'd0, 2'b11, 3'd5, 1'b0, 4'd2},  // R2
      '{1'b0, 11'd0, 3'd0, 11'd9, 2'd0, 8'h00, 2'd0, 2'b11, 3'd0, 1'b0, 4'd3},  // R3
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'hF0, 2'd0, 2'b11, 3'd3, 1'b0, 4'd4},  // R4 root turn
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'h20, 2'd0, 2'b11, 3'd4, 1'b0, 4'd4},  // R4 leaf turn
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'hFF, 2'd0, 2'b11, 3'd0, 1'b1, 4'd8},  // R8
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'h00, 2'd3, 2'b11, 3'd3, 1'b0, 4'd5},  // R5
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd1, 8'h3F, 2'd1, 2'b11, 3'd6, 1'b0, 4'd5},  // R5
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd1, 8'h3F, 2'd2, 2'b11, 3'd0, 1'b1, 4'd5},  // R5
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd2, 8'h00, 2'd3, 2'b11, 3'd5, 1'b0, 4'd6},  // R6
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd2, 8'h00, 2'd1, 2'b11, 3'd7, 1'b0, 4'd6},  // R6
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd2, 8'h00, 2'd2, 2'b11, 3'd7, 1'b0, 4'd6},  // R6
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd2, 8'h80, 2'd2, 2'b11, 3'd6, 1'b0, 4'd6},  // R6
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd2, 8'h00, 2'd0, 2'b11, 3'd0, 1'b1, 4'd6},  // R6
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'h00, 2'd0, 2'b10, 3'd0, 1'b1, 4'd7},  // R7
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd1, 8'h00, 2'd0, 2'b10, 3'd5, 1'b0, 4'd7},  // R7
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd1, 8'h00, 2'd0, 2'b01, 3'd0, 1'b1, 4'd7},  // R7
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd0, 8'h00, 2'd0, 2'b01, 3'd5, 1'b0, 4'd7},  // R7
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd1, 8'h00, 2'd0, 2'b00, 3'd0, 1'b1, 4'd7},  // R7
      '{1'b0, 11'd0, 3'd0, 11'd5, 2'd3, 8'h00, 2'd3, 2'b11, 3'd0, 1'b1, 4'd10}  // R10
   };

   task automatic check(input int req, input logic [WAY_W-1:0] exp_way,
                        input logic exp_nv);
      n_checks++;
      if (victim_way !== exp_way || no_victim !== exp_nv) begin
         n_fail++;
         $display("FAIL R%0d: victim=%0d no_victim=%0b expected victim=%0d no_victim=%0b",
                  req, victim_way, no_victim, exp_way, exp_nv);
      end
   endtask

   task automatic set_query(input logic [SET_W-1:0] s, input logic [1:0] c,
                            input logic [WAYS-1:0] lk, input logic [1:0] sc,
                            input logic [1:0] al);
      lkp_set        = s;
      req_class      = c;
      lock_mask      = lk;
      cfg_stash_ways = sc;
      cfg_alloc_en   = al;
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         touch_valid = VEC[i].tv;
         touch_set   = VEC[i].ts;
         touch_way   = VEC[i].tw;
         set_query(VEC[i].qs, VEC[i].qc, VEC[i].lk, VEC[i].sc, VEC[i].al);
         @(posedge clk);
         @(negedge clk);
         touch_valid = 1'b0;
         #1;
         check(int'(VEC[i].req), VEC[i].ew, VEC[i].en);
      end

      // R9: same-cycle lookup of the set being touched sees the old tree.
      @(negedge clk);
      set_query(11'd5, 2'd0, 8'h00, 2'd0, 2'b11);
      touch_valid = 1'b1;
      touch_set   = 11'd5;
      touch_way   = 3'd5;
      #1;
      check(9, 3'd5, 1'b0);
      @(posedge clk);
      @(negedge clk);
      touch_valid = 1'b0;
      #1;
      check(9, 3'd3, 1'b0);

      // R3: touching set 9 leaves set 5 as it was.
      @(negedge clk);
      touch_valid = 1'b1;
      touch_set   = 11'd9;
      touch_way   = 3'd3;
      @(posedge clk);
      @(negedge clk);
      touch_valid = 1'b0;
      #1;
      check(3, 3'd3, 1'b0);
      lkp_set = 11'd9;
      #1;
      check(3, 3'd4, 1'b0);

      // R1: a second reset returns every tree to way 0.
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      lkp_set = 11'd5;
      #1;
      check(1, 3'd0, 1'b0);
      lkp_set = 11'd9;
      #1;
      check(1, 3'd0, 1'b0);

      repeat (2) @(negedge clk);
      summary();
   end

endmodule